// File: doc/BRIEF.md
# I2C Master Byte Receiver

This block is the receive half of an I2C bus master. A CPU drives it through two byte-wide registers: a data register and a control/status register. Software issues a start condition and then selects receive mode. A first read of the data register returns dummy data and starts clocking the first byte in from SDA. The block shifts the eight data bits in MSB first and drives the acknowledge bit on the ninth clock. It then latches the byte, raises its flags and an optional interrupt, and stretches SCL low until software reads the byte.

Each data read both collects a byte and launches the next one, so reception can run without gaps. To end a transfer, software selects a NACK before it launches the final byte. Once that byte is in, software switches the direction bit and reads the data register, which collects the byte without clocking another. A control write then issues the stop condition. SCL and SDA are open-drain: an output of 0 pulls the line low and an output of 1 releases it. Both lines are sampled back through a synchronizer. The high and low phases of SCL each last HALF_CLKS system clocks, and the high phase starts counting once SCL is seen high.

Top module: `i2c_master_rx`

## Requirements
- R1: After reset, scl_o and sda_o are 1 and irq is 0. The control/status register (reg_addr=1) reads 0x09 and the data register (reg_addr=0) reads 0x00. Control bit map: bit0 direction (1 = transmit, 0 = receive), bit1 acknowledge select, bit2 busy, bit3 keep-bus (reads 1), bit4 interrupt flag, bit5 receive-full, bit6 interrupt enable, bit7 receive-end.
- R2: A control write with bit3=0 and bit2=1 while the bus is idle makes SDA fall while SCL is high, then holds SCL low. Bit2 reads 1 from then on.
- R3: While the bus is held and bit0=0, a data register read produces exactly nine SCL rising edges. The eight data bits are sampled MSB first. While bit0=1, a data read produces no SCL edge.
- R4: After the ninth rising edge, the data register holds the received byte and bits 5, 4 and 7 all read 1.
- R5: irq equals bit4 AND bit6, delayed by one clock.
- R6: After a byte, SCL stays low with no rising edge until the data register is read.
- R7: During the ninth clock, SDA carries bit1: SDA is low for 0 (ACK) and released for 1 (NACK).
- R8: A data read returns the latched byte and clears bit5. With bit0=0 it also launches the next byte, so bytes can be received back to back.
- R9: With bit0=1, a data read returns the byte and clears bit5, produces no SCL edge, and leaves bit7 at 1.
- R10: Bit4 is cleared only by a control write with bit4=0. A write with bit4=1 leaves it set.
- R11: A control write with bit3=0 and bit2=0 while SCL is held produces a stop: SDA rises while SCL is high. Afterwards both lines are released and bit2 reads 0.
- R12: A control write with bit3=1 never starts or stops the bus, whatever bit2 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = data register, 1 = control/status register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the clock after reg_rd |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | Sampled SCL line level |
| scl_o | output | 1 | SCL drive, 0 pulls low, 1 releases |
| sda_i | input | 1 | Sampled SDA line level |
| sda_o | output | 1 | SDA drive, 0 pulls low, 1 releases |

## Verification
The SDA steadiness check during each high phase assumes that software does not change the acknowledge select bit while a byte is being clocked. The bench writes that bit only while SCL is stretched between bytes. The hold-state check assumes that data reads and stop commands are the only events that end the stretch, and the stimulus issues no other command while the bus is held. The slave model changes SDA only after SCL falls, and it releases SDA after it sees a NACK, so the master's stop sequence always controls SDA.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;

  // control/status bit positions
  localparam int CB_DIR  = 0;
  localparam int CB_ACK  = 1;
  localparam int CB_BUSY = 2;
  localparam int CB_KEEP = 3;
  localparam int CB_IFLG = 4;
  localparam int CB_FULL = 5;
  localparam int CB_IEN  = 6;
  localparam int CB_END  = 7;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START_A, ST_START_B, ST_HOLD,
    ST_BIT_LO, ST_BIT_HI, ST_STOP_A, ST_STOP_B
  } eng_state_t;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2cm_shift.sv
module i2cm_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int HALF_CLKS = 250,
  parameter int BITS      = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_cmd,
  input  logic stop_cmd,
  input  logic launch,
  input  logic ack_sel,
  input  logic scl_s,
  output logic scl_low_q,
  output logic sda_low_q,
  output logic busy,
  output logic in_hold,
  output logic shift_en,
  output logic rx_done,
  output logic byte_start
);
  localparam int CW  = $clog2(HALF_CLKS + 1);
  localparam int BCW = $clog2(BITS + 1);
  localparam logic [CW-1:0]  CNT_END = CW'(HALF_CLKS - 1);
  localparam logic [BCW-1:0] ACK_BIT = BCW'(BITS);

  eng_state_t     state, state_d;
  logic [CW-1:0]  cnt, cnt_d;
  logic [BCW-1:0] bitn, bit_d;
  logic           seen, seen_d;
  logic           scl_low_d, sda_low_d;
  logic           half_end;

  assign half_end = (cnt == CNT_END);

  always_comb begin
    state_d    = state;
    cnt_d      = cnt;
    bit_d      = bitn;
    seen_d     = seen;
    shift_en   = 1'b0;
    rx_done    = 1'b0;
    byte_start = 1'b0;
    case (state)
      ST_IDLE: if (start_cmd) begin
        state_d = ST_START_A;
        cnt_d   = '0;
      end
      ST_START_A: if (half_end) begin
        state_d = ST_START_B;
        cnt_d   = '0;
      end else cnt_d = cnt + 1'b1;
      ST_START_B: if (half_end) begin
        state_d = ST_HOLD;
        cnt_d   = '0;
      end else cnt_d = cnt + 1'b1;
      ST_HOLD: if (stop_cmd) begin
        state_d = ST_STOP_A;
        cnt_d   = '0;
      end else if (launch) begin
        state_d    = ST_BIT_LO;
        cnt_d      = '0;
        bit_d      = '0;
        byte_start = 1'b1;
      end
      ST_BIT_LO: if (half_end) begin
        state_d = ST_BIT_HI;
        cnt_d   = '0;
        seen_d  = 1'b0;
      end else cnt_d = cnt + 1'b1;
      ST_BIT_HI: if (!seen) begin
        if (scl_s) seen_d = 1'b1;
      end else begin
        if (cnt == '0) begin
          if (bitn == ACK_BIT) rx_done = 1'b1;
          else                 shift_en = 1'b1;
        end
        if (half_end) begin
          cnt_d = '0;
          if (bitn == ACK_BIT) state_d = ST_HOLD;
          else begin
            state_d = ST_BIT_LO;
            bit_d   = bitn + 1'b1;
          end
        end else cnt_d = cnt + 1'b1;
      end
      ST_STOP_A: if (half_end) begin
        state_d = ST_STOP_B;
        cnt_d   = '0;
        seen_d  = 1'b0;
      end else cnt_d = cnt + 1'b1;
      ST_STOP_B: if (!seen) begin
        if (scl_s) seen_d = 1'b1;
      end else if (half_end) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end else cnt_d = cnt + 1'b1;
      default: state_d = ST_IDLE;
    endcase

    scl_low_d = (state_d == ST_START_B) || (state_d == ST_HOLD) ||
                (state_d == ST_BIT_LO)  || (state_d == ST_STOP_A);
    sda_low_d = (state_d == ST_START_A) || (state_d == ST_START_B) ||
                (state_d == ST_STOP_A)  || (state_d == ST_STOP_B)  ||
                (((state_d == ST_BIT_LO) || (state_d == ST_BIT_HI)) &&
                 (bit_d == ACK_BIT) && !ack_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      seen      <= 1'b0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
    end else begin
      state     <= state_d;
      cnt       <= cnt_d;
      bitn      <= bit_d;
      seen      <= seen_d;
      scl_low_q <= scl_low_d;
      sda_low_q <= sda_low_d;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign in_hold = (state == ST_HOLD);

  // R6: with no read and no stop, the stretch persists
  assert_hold_stays_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !launch && !stop_cmd) |=> (state == ST_HOLD && scl_low_q));

  // R3 / R7: master SDA never moves while SCL is in a receive high phase
  assert_sda_steady_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BIT_HI && $past(state) == ST_BIT_HI) |-> $stable(sda_low_q));

  // R11: leaving the stop sequence releases both lines
  assert_stop_release_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP_B && state_d == ST_IDLE) |=> (!sda_low_q && !scl_low_q));
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              busy,
  input  logic              in_hold,
  input  logic              rx_done,
  input  logic              byte_start,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              start_cmd,
  output logic              stop_cmd,
  output logic              launch,
  output logic              ack_sel
);
  logic [BYTE_W-1:0] data_q, rdata_q, ctrl_view;
  logic dir_q, ack_q, ien_q, iflg_q, full_q, end_q, irq_q;
  logic wr_ctrl, rd_data, bus_cmd;
  logic unused_wbits;

  assign unused_wbits = reg_wdata[CB_FULL] ^ reg_wdata[CB_END];
  assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
  assign rd_data   = reg_rd && (reg_addr == ADDR_DATA);
  assign bus_cmd   = wr_ctrl && !reg_wdata[CB_KEEP];
  assign start_cmd = bus_cmd && reg_wdata[CB_BUSY] && !busy;
  assign stop_cmd  = bus_cmd && !reg_wdata[CB_BUSY] && in_hold;
  assign launch    = rd_data && !dir_q && in_hold;
  assign ack_sel   = ack_q;

  always_comb begin
    ctrl_view          = '0;
    ctrl_view[CB_DIR]  = dir_q;
    ctrl_view[CB_ACK]  = ack_q;
    ctrl_view[CB_BUSY] = busy;
    ctrl_view[CB_KEEP] = 1'b1;
    ctrl_view[CB_IFLG] = iflg_q;
    ctrl_view[CB_FULL] = full_q;
    ctrl_view[CB_IEN]  = ien_q;
    ctrl_view[CB_END]  = end_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      rdata_q <= '0;
      dir_q   <= 1'b1;
      ack_q   <= 1'b0;
      ien_q   <= 1'b0;
      iflg_q  <= 1'b0;
      full_q  <= 1'b0;
      end_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        dir_q <= reg_wdata[CB_DIR];
        ack_q <= reg_wdata[CB_ACK];
        ien_q <= reg_wdata[CB_IEN];
      end
      if (reg_rd) rdata_q <= (reg_addr == ADDR_CTRL) ? ctrl_view : data_q;

      if (rx_done) data_q <= rx_byte;

      if (rx_done)      full_q <= 1'b1;
      else if (rd_data) full_q <= 1'b0;

      if (rx_done)                               iflg_q <= 1'b1;
      else if (wr_ctrl && !reg_wdata[CB_IFLG])   iflg_q <= 1'b0;

      if (rx_done)                        end_q <= 1'b1;
      else if (byte_start || start_cmd)   end_q <= 1'b0;

      irq_q <= iflg_q && ien_q;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;

  // R4: a completed byte raises all three completion flags
  assert_flags_on_done_R4: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> (full_q && iflg_q && end_q));

  // R5: irq follows flag and enable one clock later
  assert_irq_follows_R5: assert property (@(posedge clk) disable iff (rst)
    (iflg_q && ien_q) |=> irq);
  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!iflg_q || !ien_q) |=> !irq);

  // R10: only a write of 0 clears the interrupt flag
  assert_iflag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (iflg_q && !(wr_ctrl && !reg_wdata[CB_IFLG])) |=> iflg_q);

  // R8: a data read empties the receive-full flag unless a byte lands at once
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !rx_done) |=> !full_q);
endmodule

// File: rtl/i2c_master_rx.sv
module i2c_master_rx
  import i2cm_pkg::*;
#(
  parameter int HALF_CLKS   = 250,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              scl_i,
  output logic              scl_o,
  input  logic              sda_i,
  output logic              sda_o
);
  logic scl_s, sda_s;
  logic scl_low_q, sda_low_q;
  logic busy, in_hold, shift_en, rx_done, byte_start;
  logic start_cmd, stop_cmd, launch, ack_sel;
  logic [BYTE_W-1:0] rx_byte;

  i2cm_sync #(.STAGES(SYNC_STAGES)) i_sync_scl (
    .clk(clk), .rst(rst), .din(scl_i), .dout(scl_s));
  i2cm_sync #(.STAGES(SYNC_STAGES)) i_sync_sda (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_s));

  i2cm_engine #(.HALF_CLKS(HALF_CLKS), .BITS(BYTE_W)) i_engine (
    .clk(clk), .rst(rst),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd), .launch(launch),
    .ack_sel(ack_sel), .scl_s(scl_s),
    .scl_low_q(scl_low_q), .sda_low_q(sda_low_q),
    .busy(busy), .in_hold(in_hold), .shift_en(shift_en),
    .rx_done(rx_done), .byte_start(byte_start));

  i2cm_shift #(.W(BYTE_W)) i_shift (
    .clk(clk), .rst(rst), .en(shift_en), .din(sda_s), .q(rx_byte));

  i2cm_regs i_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .busy(busy), .in_hold(in_hold), .rx_done(rx_done),
    .byte_start(byte_start), .rx_byte(rx_byte),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .launch(launch), .ack_sel(ack_sel));

  assign scl_o = !scl_low_q;
  assign sda_o = !sda_low_q;
endmodule

// File: tb/test_i2c_master_rx.sv
module test_i2c_master_rx;
  localparam int HALF = 5;
  localparam int NBYTES = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq, scl_o, sda_o;
  logic sda_slave = 1'b1;
  logic slave_clr = 1'b1;
  logic scl_bus, sda_bus;

  int checks = 0, failures = 0;
  int bitpos = 0, idx = 0, scl_rises = 0, starts = 0, stops = 0;
  logic nack_done = 1'b0, last_ack = 1'b0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;

  assign scl_bus = scl_o;
  assign sda_bus = sda_o & sda_slave;

  always #5 clk = ~clk;

  i2c_master_rx #(.HALF_CLKS(HALF), .SYNC_STAGES(2)) i_i2c_master_rx (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .scl_i(scl_bus), .scl_o(scl_o), .sda_i(sda_bus), .sda_o(sda_o));

  function automatic logic [7:0] pattern(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  // slave and bus monitor in one process
  always @(scl_bus, sda_bus, slave_clr) begin
    if (slave_clr) begin
      bitpos = 0; idx = 0; scl_rises = 0; starts = 0; stops = 0;
      nack_done = 1'b0; sda_slave = 1'b1;
    end else begin
      if (scl_bus === 1'b1 && prev_scl === 1'b0) begin
        scl_rises++;
        if (bitpos == 8) begin
          last_ack = sda_bus;
          if (sda_bus) nack_done = 1'b1;
          bitpos = 0;
          idx++;
        end else bitpos++;
      end
      if (scl_bus === 1'b0 && prev_scl === 1'b1) begin
        if (nack_done || bitpos >= 8) sda_slave = 1'b1;
        else begin
          logic [7:0] b;
          b = pattern(idx);
          sda_slave = b[7 - bitpos];
        end
      end
      if (scl_bus === 1'b1 && prev_sda === 1'b1 && sda_bus === 1'b0) starts++;
      if (scl_bus === 1'b1 && prev_sda === 1'b0 && sda_bus === 1'b1) stops++;
    end
    prev_scl = scl_bus;
    prev_sda = sda_bus;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // watchdog
  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int base;
    idle(5);
    @(negedge clk) rst = 1'b0;
    idle(2);
    // R1 reset state
    chk("R1 scl_o", int'(scl_o), 1);
    chk("R1 sda_o", int'(sda_o), 1);
    chk("R1 irq", int'(irq), 0);
    cpu_read(1'b1, rd); chk("R1 ctrl", int'(rd), 8'h09);
    cpu_read(1'b0, rd); chk("R1 data", int'(rd), 8'h00);
    slave_clr = 1'b0;
    idle(2);

    // R12: keep-bus set, busy bit set: no start
    cpu_write(1'b1, 8'h0D);
    idle(40);
    chk("R12 no start", starts, 0);
    cpu_read(1'b1, rd); chk("R12 busy bit", int'(rd[2]), 0);

    // R2: start
    cpu_write(1'b1, 8'h05);
    idle(40);
    chk("R2 start seen", starts, 1);
    chk("R2 scl held", int'(scl_o), 0);
    cpu_read(1'b1, rd); chk("R2 busy bit", int'(rd[2]), 1);

    // R3: data read in transmit direction launches nothing
    cpu_read(1'b0, rd);
    idle(60);
    chk("R3 no clocks when dir=1", scl_rises, 0);

    // receive mode, interrupts enabled, ACK
    cpu_write(1'b1, 8'h48);
    base = scl_rises;
    cpu_read(1'b0, rd);  // dummy read launches byte 0
    for (int k = 0; k < NBYTES; k++) begin
      while (irq !== 1'b1) @(negedge clk);
      chk("R3 nine clocks", scl_rises - base, 9);
      chk("R7 ack level", int'(last_ack), (k == NBYTES - 1) ? 1 : 0);
      cpu_read(1'b1, rd);
      chk("R4 flags", int'(rd), 8'hFC | ((k == NBYTES - 1) ? 8'h02 : 8'h00));
      if (k < 3) begin
        idle(30);
        chk("R6 stretched", scl_rises - base, 9);
        chk("R6 scl low", int'(scl_o), 0);
      end
      if (k == 0) begin
        cpu_write(1'b1, 8'h58);
        cpu_read(1'b1, rd);
        chk("R10 write 1 keeps flag", int'(rd[4]), 1);
        chk("R10 irq kept", int'(irq), 1);
      end
      cpu_write(1'b1, 8'h48 | ((k >= NBYTES - 2) ? 8'h02 : 8'h00));
      @(negedge clk);
      chk("R5 irq drops", int'(irq), 0);
      if (k == 0) begin
        cpu_read(1'b1, rd);
        chk("R10 write 0 clears", int'(rd[4]), 0);
      end
      if (k < NBYTES - 1) begin
        base = scl_rises;
        cpu_read(1'b0, rd);
        chk("R8 data", int'(rd), int'(pattern(k)));
        cpu_read(1'b1, rd);
        chk("R8 full cleared", int'(rd[5]), 0);
      end else begin
        cpu_write(1'b1, 8'h4B);
        base = scl_rises;
        cpu_read(1'b0, rd);
        chk("R9 last data", int'(rd), int'(pattern(k)));
        idle(60);
        chk("R9 no clocks", scl_rises - base, 0);
        cpu_read(1'b1, rd);
        chk("R9 full cleared", int'(rd[5]), 0);
        chk("R9 end kept", int'(rd[7]), 1);
      end
    end

    // R11: stop
    cpu_write(1'b1, 8'h01);
    idle(40);
    chk("R11 stop seen", stops, 1);
    chk("R11 scl released", int'(scl_o), 1);
    chk("R11 sda released", int'(sda_o), 1);
    cpu_read(1'b1, rd); chk("R11 busy bit", int'(rd[2]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule